// File: doc/BRIEF.md
# System Clock Divider Ratio-Change Controller

This block drives several programmable clock dividers from one shared source clock. Each divider has a 5-bit ratio and an enable. Software writes new ratios into holding registers, and those writes leave the running outputs alone. A separate command then starts a coordinated switch. During the switch a busy flag reads 1 and every divided output is held low. When the switch ends, all dividers load their new ratios at once and restart in phase.

The divided outputs are registered data signals in the source-clock domain. Clock-tree gating cells placed downstream turn them into real clocks. Software programs the held ratios, confirms that busy reads 0, issues the command, and polls busy until it clears. There is no required frequency relationship between the dividers.

Top module: `sysclk_ratio_ctrl`

## Requirements
- R1: After reset, busy reads 0. Every divider is enabled with ratio field 1 (divide-by-2). Its output is high in the first cycle after reset, and every divider register reads 0x81.
- R2: Register map. Address 0 is command/status: a write with bit 0 set is the switch command, and a read returns busy in bit 1. Address 1+i belongs to divider i: the ratio is in bits 4:0 and the enable is in bit 7. Other bits read 0.
- R3: A ratio write does not change any output waveform until a switch command is accepted.
- R4: A switch command accepted while idle sets busy from the next cycle. Busy stays 1 for exactly N cycles. N is the largest divide factor among enabled dividers, taking both the current and the held ratio into account, plus 2. With no divider enabled, N is 2.
- R5: A switch command written while busy is ignored, so the end of the current switch does not move. Bit 0 of address 0 always reads 0.
- R6: While busy is 1, all divided outputs are low.
- R7: When busy clears, every divider adopts its held ratio and restarts from count 0 in the same cycle. An enabled divider with a factor of at least 2 is high in the first cycle after busy clears.
- R8: Ratio field R gives divide-by D = R+1. The output is high for floor(D/2) cycles, then low for ceil(D/2) cycles. With D = 1 the output stays low.
- R9: A divider with its enable at 0 holds its output low and its count at 0, and it does not lengthen a switch.
- R10: An enable write takes effect in the next cycle without a switch command. A re-enabled divider starts its period at count 0.
- R11: The two dividers accept any pair of ratios, odd or even, with no relation between them.
- R12: Read data updates in the cycle after a read strobe and holds its value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for all dividers |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| div_out | output | NUM_DIV | Divided clock outputs, one bit per divider |

## Verification
A walk through the stimulus table switches between ratio pairs that are even with odd, divide-by-1 with divide-by-8, and divide-by-32 with a disabled partner. Each step measures how many cycles busy stays high. That count shows whether N is taken from the old factor, the new factor, or only the enabled dividers. After each switch, 64 output samples are compared against the expected high/low phase pattern. These samples separate a correct duty split and in-phase restart from an off-by-one phase. Directed cases cover the following:
- held ratios leaving the old waveform unchanged
- a second command injected in mid-switch
- immediate re-enable
- read-data hold when no read strobe is given

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int RATIO_W  = 5;
    localparam int DATA_W   = 8;
    localparam int EN_BIT   = 7;
    localparam int GO_BIT   = 0;
    localparam int BUSY_BIT = 1;
    localparam int FACT_W   = RATIO_W + 1;
    localparam int TMR_W    = FACT_W + 1;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [FACT_W-1:0]  factor_t;
    typedef logic [TMR_W-1:0]   timer_t;

    typedef struct packed {
        logic   en;
        ratio_t ratio;
    } div_cfg_t;

    typedef enum logic {ST_RUN, ST_SWITCH} seq_state_e;

    function automatic factor_t factor_of(ratio_t r);
        return factor_t'(r) + factor_t'(1);
    endfunction

    function automatic factor_t high_len(ratio_t r);
        return factor_of(r) >> 1;
    endfunction
endpackage

// File: rtl/cdc_regs.sv
`timescale 1ns/1ps
module cdc_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV     = 2,
    parameter int ADDR_W      = 2,
    parameter int RESET_RATIO = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           busy,
    output div_cfg_t [NUM_DIV-1:0]         cfg,
    output logic                           go_req,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] rd_mux;

    assign go_req = wr_en && (addr == '0) && wdata[GO_BIT];

    always_comb begin
        rd_mux = '0;
        if (addr == '0) begin
            rd_mux[BUSY_BIT] = busy;
        end
        for (int i = 0; i < NUM_DIV; i++) begin
            if (addr == ADDR_W'(i + 1)) begin
                rd_mux[EN_BIT]        = cfg[i].en;
                rd_mux[RATIO_W-1:0]   = cfg[i].ratio;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DIV; i++) begin
                cfg[i].en    <= 1'b1;
                cfg[i].ratio <= ratio_t'(RESET_RATIO);
            end
            rdata <= '0;
        end else begin
            if (wr_en) begin
                for (int i = 0; i < NUM_DIV; i++) begin
                    if (addr == ADDR_W'(i + 1)) begin
                        cfg[i].en    <= wdata[EN_BIT];
                        cfg[i].ratio <= wdata[RATIO_W-1:0];
                    end
                end
            end
            if (rd_en) begin
                rdata <= rd_mux;
            end
        end
    end

    // R5: the command bit never reads back as 1
    assert_go_readback_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == '0) |=> (rdata[GO_BIT] == 1'b0));

    // R12: read data holds without a read strobe
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/cdc_seq.sv
`timescale 1ns/1ps
module cdc_seq
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go_req,
    input  div_cfg_t [NUM_DIV-1:0]  cfg,
    input  ratio_t   [NUM_DIV-1:0]  act_ratio,
    output logic                    busy,
    output logic                    load
);
    seq_state_e state;
    timer_t     timer;
    timer_t     need;

    always_comb begin
        factor_t big;
        need = timer_t'(2);
        for (int i = 0; i < NUM_DIV; i++) begin
            big = factor_of(act_ratio[i]);
            if (factor_of(cfg[i].ratio) > big) begin
                big = factor_of(cfg[i].ratio);
            end
            if (cfg[i].en && (timer_t'(big) + timer_t'(2) > need)) begin
                need = timer_t'(big) + timer_t'(2);
            end
        end
    end

    assign busy = (state == ST_SWITCH);
    assign load = busy && (timer == timer_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            timer <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (go_req) begin
                        state <= ST_SWITCH;
                        timer <= need;
                    end
                end
                ST_SWITCH: begin
                    timer <= timer - timer_t'(1);
                    if (timer == timer_t'(1)) begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // R4: an accepted command raises busy in the next cycle
    assert_go_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (go_req && !busy) |=> busy);

    // R5: the countdown is not disturbed by commands while busy
    assert_go_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (busy && timer == $past(timer) - timer_t'(1)));

    // R4: the switch ends right after the load cycle
    assert_load_ends_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> !busy);
endmodule

// File: rtl/cdc_divider.sv
`timescale 1ns/1ps
module cdc_divider
    import clkdiv_pkg::*;
#(
    parameter int RESET_RATIO = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   busy,
    input  logic   load,
    input  ratio_t new_ratio,
    output logic   div_o,
    output ratio_t act_ratio
);
    ratio_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            act_ratio <= ratio_t'(RESET_RATIO);
        end else if (load) begin
            cnt       <= '0;
            act_ratio <= new_ratio;
        end else if (!en) begin
            cnt <= '0;
        end else if (busy) begin
            if (cnt != act_ratio) begin
                cnt <= cnt + ratio_t'(1);
            end
        end else begin
            cnt <= (cnt == act_ratio) ? '0 : cnt + ratio_t'(1);
        end
    end

    assign div_o = en && !busy && (factor_t'(cnt) < high_len(act_ratio));

    // R7: an enabled counter has parked at terminal count before the load
    assert_terminal_before_load_R7: assert property (@(posedge clk) disable iff (rst)
        (load && en) |-> (cnt == act_ratio));

    // R7: all counters restart from zero after the load
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == '0));

    // R8: the count never passes the terminal value
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= act_ratio);

    // R9: a disabled divider keeps its count at zero
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));
endmodule

// File: rtl/sysclk_ratio_ctrl.sv
`timescale 1ns/1ps
module sysclk_ratio_ctrl
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV     = 2,
    parameter int ADDR_W      = 2,
    parameter int RESET_RATIO = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_DIV-1:0]  div_out
);
    div_cfg_t [NUM_DIV-1:0] cfg;
    ratio_t   [NUM_DIV-1:0] act_ratio;
    logic                   go_req;
    logic                   busy;
    logic                   load;

    cdc_regs #(
        .NUM_DIV     (NUM_DIV),
        .ADDR_W      (ADDR_W),
        .RESET_RATIO (RESET_RATIO)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .busy   (busy),
        .cfg    (cfg),
        .go_req (go_req),
        .rdata  (rdata)
    );

    cdc_seq #(
        .NUM_DIV (NUM_DIV)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_req    (go_req),
        .cfg       (cfg),
        .act_ratio (act_ratio),
        .busy      (busy),
        .load      (load)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        cdc_divider #(
            .RESET_RATIO (RESET_RATIO)
        ) u_div (
            .clk       (clk),
            .rst       (rst),
            .en        (cfg[g].en),
            .busy      (busy),
            .load      (load),
            .new_ratio (cfg[g].ratio),
            .div_o     (div_out[g]),
            .act_ratio (act_ratio[g])
        );
    end

    // R6: every output is paused while the switch runs
    assert_pause_low_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (div_out == '0));
endmodule

// File: tb/test_sysclk_ratio_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_ratio_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] div_out;

    sysclk_ratio_ctrl i_sysclk_ratio_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .div_out(div_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model
    bit en_m [2];
    int act_m [2];
    int pend_m [2];
    int ph [2];

    // {en_a, en_b, ratio_a, ratio_b, expected busy cycles}
    localparam logic [17:0] VECS [0:6] = '{
        {1'b1, 1'b1, 5'd3,  5'd2,  6'd6},
        {1'b1, 1'b1, 5'd0,  5'd7,  6'd10},
        {1'b1, 1'b0, 5'd31, 5'd4,  6'd34},
        {1'b1, 1'b1, 5'd5,  5'd5,  6'd34},
        {1'b0, 1'b1, 5'd1,  5'd9,  6'd12},
        {1'b1, 1'b1, 5'd2,  5'd0,  6'd12},
        {1'b0, 1'b0, 5'd6,  5'd6,  6'd2}
    };
    logic [17:0] e;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_out(input int i);
        int d;
        d = act_m[i] + 1;
        return en_m[i] && ((ph[i] % d) < (d / 2));
    endfunction

    task automatic tick();
        @(posedge clk);
        for (int i = 0; i < 2; i++) ph[i] = en_m[i] ? ph[i] + 1 : 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
        if (a != 2'd0) begin
            en_m[a-1]   = d[7];
            pend_m[a-1] = int'(d[4:0]);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic check_wave(input int n, input string req);
        int bad [2];
        int first_a [2];
        int first_e [2];
        bad[0] = 0; bad[1] = 0;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 2; i++) begin
                if (div_out[i] !== exp_out(i)) begin
                    if (bad[i] == 0) begin
                        first_a[i] = int'(div_out[i]);
                        first_e[i] = int'(exp_out(i));
                    end
                    bad[i]++;
                end
            end
            tick();
        end
        for (int i = 0; i < 2; i++)
            chk(bad[i] == 0, req, bad[i] == 0 ? 0 : first_a[i], bad[i] == 0 ? 0 : first_e[i]);
    endtask

    // issue the switch command and count busy cycles via status reads
    task automatic go_measure(input int inject_k, output int cnt);
        bit hi_seen [0:199];
        bit done;
        int k;
        int viol;
        wr_en = 1'b1; addr = 2'd0; wdata = 8'h01; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        hi_seen[0] = (div_out != 2'b00);
        cnt = 0; k = 0; done = 0;
        while (!done && k < 199) begin
            if (inject_k != 0 && k == inject_k) begin
                wr_en = 1'b1; wdata = 8'h01;
            end
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            k++;
            hi_seen[k] = (div_out != 2'b00);
            if (rdata[1]) cnt++;
            else if (cnt > 0) done = 1;
        end
        rd_en = 1'b0;
        viol = 0;
        for (int j = 0; j < cnt && j < 200; j++) if (hi_seen[j]) viol++;
        chk(viol == 0, "R6 outputs low during switch", viol, 0);
        for (int i = 0; i < 2; i++) begin
            act_m[i] = pend_m[i];
            ph[i] = en_m[i] ? 1 : 0;
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        for (int i = 0; i < 2; i++) begin
            en_m[i] = 1; act_m[i] = 1; pend_m[i] = 1; ph[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(div_out == 2'b11, "R1 outputs after reset", int'(div_out), 3);
        rd(2'd1, d); chk(d == 8'h81, "R1 R2 divider A reset value", int'(d), 8'h81);
        rd(2'd2, d); chk(d == 8'h81, "R1 R2 divider B reset value", int'(d), 8'h81);
        rd(2'd0, d); chk(d == 8'h00, "R1 status idle", int'(d), 0);

        // R3 held ratio does not touch the running waveform
        wr(2'd1, 8'h85);
        wr(2'd2, 8'h9F);
        rd(2'd1, d); chk(d == 8'h85, "R2 held ratio readback", int'(d), 8'h85);
        check_wave(20, "R3 old waveform kept before switch");

        // table walk: R4 switch length, R7 R8 R11 waveform after switch
        for (int v = 0; v < 7; v++) begin
            e = VECS[v];
            wr(2'd1, {e[17], 2'b00, e[15:11]});
            wr(2'd2, {e[16], 2'b00, e[10:6]});
            go_measure(0, n);
            chk(n == int'(e[5:0]), "R4 R9 busy length", n, int'(e[5:0]));
            check_wave(64, "R7 R8 R11 waveform after switch");
        end

        // R9 disabled dividers stay low (state after last vector)
        chk(div_out == 2'b00, "R9 disabled outputs low", int'(div_out), 0);

        // R10 immediate re-enable, period starts at count 0
        wr(2'd1, 8'h86);
        chk(div_out[0] == 1'b1, "R10 re-enable starts high", int'(div_out[0]), 1);
        check_wave(14, "R10 waveform after re-enable");

        // R5 command during switch ignored
        wr(2'd1, 8'h83);
        wr(2'd2, 8'h82);
        go_measure(3, n);
        chk(n == 9, "R5 busy length with extra command", n, 9);
        check_wave(24, "R5 waveform after switch");
        rd(2'd0, d);
        chk(d == 8'h00, "R5 command bit reads 0", int'(d), 0);

        // R12 read data holds without strobe
        addr = 2'd1;
        tick();
        chk(rdata == 8'h00, "R12 read data hold", int'(rdata), 0);
        rd(2'd1, d);
        chk(d == 8'h83, "R12 read data update", int'(d), 8'h83);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule